// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is the register front end of an on-chip flash plane. Software programs a timing mode register, writes command words into a command register and polls a status register. A command word carries a protection key, a page number and an operation code. The block validates the key and the code, and checks the page against per-region lock bits. It then either flags an error or starts a timed busy period. The cell array and its programming pulses are not modelled: an accepted operation is a counted busy window, and completion updates the lock or option bits.

Lock bits protect groups of pages from page programming and from erase of the whole plane. They take effect as soon as a set or clear operation finishes. General-purpose option bits are stored at once but are shown in the status register only after the controller has been reset. A separate power-on reset clears their storage. The security state comes in on a pin and is mirrored in the status register.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status register (address 2) reads 0x00000001: ready set, every flag and lock bit clear. The mode register (address 0) reads 0.
- R2: A command word (address 1) whose bits 31:24 are not 0x5A sets the invalid flag (status bit 3) and runs nothing. Ready stays 1 and the lock bits are unchanged.
- R3: An accepted command clears ready (status bit 0) for exactly BUSY_CYCLES cycles after the clock edge that accepts it. Ready then returns to 1.
- R4: The valid codes are 0x01 page write, 0x02 lock set, 0x04 lock clear, 0x08 erase plane, 0x0B option bit set and 0x0D option bit clear, with the page in bits 17:8. Any other code sets status bit 3. So does a page-based command whose page lies beyond NUM_REGIONS regions, or an option command whose index (page field) is at least NUM_GPNVM.
- R5: The lock region is the page number divided by 32 for 128-byte pages, or by 64 for 256-byte pages. Lock set and lock clear change status bit 16+region when the busy window ends.
- R6: A page write into a locked region sets the lock error flag (status bit 2), is dropped, and leaves ready at 1.
- R7: Erase acts only on the whole plane. It is refused with status bit 2 if any lock bit is set, and runs as a busy window otherwise.
- R8: A command word written while busy is ignored. It raises no flag, changes no lock bit and does not restart the busy window.
- R9: A status read strobe clears status bits 3:1 on the next edge, unless a new event sets them in the same cycle.
- R10: Option set and clear update the stored option bits at completion. Status bits 8 upward keep the value they had since the last reset, and show the stored value from the first clock edge after reset release.
- R11: Mode register writes are accepted at any time. Bits 23:16 hold cycles per microsecond and bits 9:8 hold wait states. They read back in place, and all other bits read 0.
- R12: With USE_EOL=1 (the default), completion of lock set or lock clear also sets the end-of-lock flag, status bit 1. Other commands never set it.
- R13: Status bit 4 mirrors the secure_i pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous controller reset |
| por_ni | input | 1 | Active-low power-on reset of the option bit storage |
| secure_i | input | 1 | Security state mirrored to status bit 4 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status flags) |
| reg_addr_i | input | 2 | Register select: 0 mode, 1 command, 2 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |

## Verification
On every cycle the assertions check these rules: ready falls after each accepted command and returns at completion, and the busy counter stays within its range. A write while busy neither restarts the counter nor raises a flag. A lock error leaves the controller idle, a read clears the error flags, and the visible option bits stay frozen outside the reload cycle after reset. The region arithmetic needs the bench's scenarios, and so do erase refusal under locks, the 0x5A key, bad codes and out-of-plane pages. The scenarios also show the option bits appearing only after a reset pulse and the end-of-lock flag on lock commands. A behavioural model compares every status and mode read against the design.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam logic [7:0] CMD_KEY = 8'h5A;

  localparam logic [7:0] OP_WP   = 8'h01;
  localparam logic [7:0] OP_SLB  = 8'h02;
  localparam logic [7:0] OP_CLB  = 8'h04;
  localparam logic [7:0] OP_EA   = 8'h08;
  localparam logic [7:0] OP_SGPB = 8'h0B;
  localparam logic [7:0] OP_CGPB = 8'h0D;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CMD  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int ST_READY  = 0;
  localparam int ST_EOL    = 1;
  localparam int ST_LOCKE  = 2;
  localparam int ST_INV    = 3;
  localparam int ST_SECURE = 4;
  localparam int ST_GP_LSB = 8;
  localparam int ST_LK_LSB = 16;

  typedef struct packed {
    logic [7:0] key;
    logic [5:0] rsv;
    logic [9:0] page;
    logic [7:0] code;
  } cmd_word_t;
endpackage

// File: rtl/flc_decode.sv
module flc_decode
  import flc_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int PPR         = 32,
  parameter int NUM_GPNVM   = 2,
  parameter int RW          = 4,
  parameter int GW          = 1
) (
  input  logic [31:0]            cmd_i,
  input  logic [NUM_REGIONS-1:0] locks_i,
  output logic                   ok_o,
  output logic                   inv_o,
  output logic                   lock_err_o,
  output logic [7:0]             code_o,
  output logic [RW-1:0]          region_o,
  output logic [GW-1:0]          gp_o
);
  localparam int PSH = $clog2(PPR);

  cmd_word_t  w;
  logic [9:0] region_full;
  logic       in_plane, gp_ok, key_ok, valid, locked;

  assign w           = cmd_i;
  assign region_full = w.page >> PSH;
  assign in_plane    = region_full < 10'(NUM_REGIONS);
  assign gp_ok       = w.page < 10'(NUM_GPNVM);
  assign key_ok      = (w.key == CMD_KEY);
  assign region_o    = region_full[RW-1:0];
  assign gp_o        = w.page[GW-1:0];
  assign code_o      = w.code;

  always_comb begin
    valid  = 1'b0;
    locked = 1'b0;
    case (w.code)
      OP_WP: begin
        valid  = in_plane;
        locked = in_plane && locks_i[region_o];
      end
      OP_SLB, OP_CLB:   valid = in_plane;
      OP_EA: begin
        valid  = 1'b1;
        locked = |locks_i;
      end
      OP_SGPB, OP_CGPB: valid = gp_ok;
      default:          valid = 1'b0;
    endcase
  end

  assign inv_o      = !key_ok || !valid;
  assign lock_err_o = key_ok && valid && locked;
  assign ok_o       = key_ok && valid && !locked;
endmodule

// File: rtl/flc_timer.sv
module flc_timer #(
  parameter int CYCLES = 8,
  parameter int CW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);
  assign done_o  = (cnt_q == CW'(1));
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/flc_nvstate.sv
module flc_nvstate
  import flc_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_GPNVM   = 2,
  parameter int RW          = 4,
  parameter int GW          = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   por_ni,
  input  logic                   done_i,
  input  logic [7:0]             op_i,
  input  logic [RW-1:0]          region_i,
  input  logic [GW-1:0]          gp_i,
  output logic [NUM_REGIONS-1:0] locks_o,
  output logic [NUM_GPNVM-1:0]   gp_vis_o,
  output logic                   pend_o
);
  logic [NUM_REGIONS-1:0] locks_q;
  logic [NUM_GPNVM-1:0]   gp_store_q, gp_vis_q;
  logic                   pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locks_q <= '0;
    end else if (done_i) begin
      if (op_i == OP_SLB) locks_q[region_i] <= 1'b1;
      if (op_i == OP_CLB) locks_q[region_i] <= 1'b0;
    end
  end

  // storage survives controller reset; only power-on clears it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      gp_store_q <= '0;
    end else if (done_i) begin
      if (op_i == OP_SGPB) gp_store_q[gp_i] <= 1'b1;
      if (op_i == OP_CGPB) gp_store_q[gp_i] <= 1'b0;
    end
  end

  // visible copy reloads once after each controller reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gp_vis_q <= '0;
      pend_q   <= 1'b1;
    end else if (pend_q) begin
      gp_vis_q <= gp_store_q;
      pend_q   <= 1'b0;
    end
  end

  assign locks_o  = locks_q;
  assign gp_vis_o = gp_vis_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flc_pkg::*;
#(
  parameter int PAGE_BYTES  = 128,
  parameter int NUM_REGIONS = 16,
  parameter int NUM_GPNVM   = 2,
  parameter int BUSY_CYCLES = 8,
  parameter bit USE_EOL     = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_ni,
  input  logic        secure_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o
);
  localparam int PPR = (PAGE_BYTES == 256) ? 64 : 32;
  localparam int RW  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int GW  = (NUM_GPNVM > 1) ? $clog2(NUM_GPNVM) : 1;
  localparam int CW  = $clog2(BUSY_CYCLES + 1);

  logic                   cmd_wr, stat_rd, ready, done;
  logic                   dec_ok, dec_inv, dec_lock;
  logic                   start, inv_set, lock_set;
  logic [7:0]             dec_code, op_q;
  logic [RW-1:0]          dec_region, region_q;
  logic [GW-1:0]          dec_gp, gp_q;
  logic [CW-1:0]          cnt;
  logic [NUM_REGIONS-1:0] locks;
  logic [NUM_GPNVM-1:0]   gp_vis;
  logic                   pend;
  logic                   inv_q, locke_q, eol;
  logic [7:0]             fmcn_q;
  logic [1:0]             fws_q;
  logic [31:0]            status;

  assign cmd_wr   = reg_wr_i && (reg_addr_i == ADDR_CMD);
  assign stat_rd  = reg_rd_i && (reg_addr_i == ADDR_STAT);
  assign start    = cmd_wr && ready && dec_ok;
  assign inv_set  = cmd_wr && ready && dec_inv;
  assign lock_set = cmd_wr && ready && dec_lock;

  flc_decode #(
    .NUM_REGIONS(NUM_REGIONS), .PPR(PPR), .NUM_GPNVM(NUM_GPNVM), .RW(RW), .GW(GW)
  ) u_dec (
    .cmd_i(reg_wdata_i), .locks_i(locks), .ok_o(dec_ok), .inv_o(dec_inv),
    .lock_err_o(dec_lock), .code_o(dec_code), .region_o(dec_region), .gp_o(dec_gp)
  );

  flc_timer #(.CYCLES(BUSY_CYCLES), .CW(CW)) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .ready_o(ready), .done_o(done), .cnt_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= '0;
      region_q <= '0;
      gp_q     <= '0;
    end else if (start) begin
      op_q     <= dec_code;
      region_q <= dec_region;
      gp_q     <= dec_gp;
    end
  end

  flc_nvstate #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_GPNVM(NUM_GPNVM), .RW(RW), .GW(GW)
  ) u_nv (
    .clk_i, .rst_ni, .por_ni, .done_i(done), .op_i(op_q), .region_i(region_q),
    .gp_i(gp_q), .locks_o(locks), .gp_vis_o(gp_vis), .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q   <= 1'b0;
      locke_q <= 1'b0;
    end else begin
      if (inv_set)       inv_q <= 1'b1;
      else if (stat_rd)  inv_q <= 1'b0;
      if (lock_set)      locke_q <= 1'b1;
      else if (stat_rd)  locke_q <= 1'b0;
    end
  end

  generate
    if (USE_EOL) begin : g_eol
      logic eol_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                     eol_q <= 1'b0;
        else if (done && (op_q == OP_SLB || op_q == OP_CLB)) eol_q <= 1'b1;
        else if (stat_rd)                                eol_q <= 1'b0;
      end
      assign eol = eol_q;
    end else begin : g_no_eol
      assign eol = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmcn_q <= '0;
      fws_q  <= '0;
    end else if (reg_wr_i && reg_addr_i == ADDR_MODE) begin
      fmcn_q <= reg_wdata_i[23:16];
      fws_q  <= reg_wdata_i[9:8];
    end
  end

  always_comb begin
    status                                = '0;
    status[ST_READY]                      = ready;
    status[ST_EOL]                        = eol;
    status[ST_LOCKE]                      = locke_q;
    status[ST_INV]                        = inv_q;
    status[ST_SECURE]                     = secure_i;
    status[ST_GP_LSB +: NUM_GPNVM]        = gp_vis;
    status[ST_LK_LSB +: NUM_REGIONS]      = locks;
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_MODE: reg_rdata_o = {8'h00, fmcn_q, 6'h00, fws_q, 8'h00};
      ADDR_STAT: reg_rdata_o = status;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int BUSY_CYCLES = 8,
  parameter int CW          = 4,
  parameter int NG          = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          lock_set_i,
  input logic          inv_set_i,
  input logic          cmd_wr_i,
  input logic          stat_rd_i,
  input logic          ready_i,
  input logic          done_i,
  input logic [CW-1:0] cnt_i,
  input logic [31:0]   status_i,
  input logic [NG-1:0] gp_vis_i,
  input logic          pend_i
);
  a_r3_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_i);

  a_r3_ready_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ready_i);

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(BUSY_CYCLES));

  a_r8_busy_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cnt_i > CW'(1)) |=> (cnt_i == $past(cnt_i) - 1'b1));

  a_r8_busy_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !ready_i && !stat_rd_i) |=> $stable(status_i[3:2]));

  a_r6_lock_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_set_i |=> (ready_i && status_i[2]));

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !inv_set_i && !lock_set_i) |=> (status_i[3:2] == 2'b00));

  a_r10_vis_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i |=> $stable(gp_vis_i));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
  .BUSY_CYCLES(BUSY_CYCLES), .CW(CW), .NG(NUM_GPNVM)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .lock_set_i(lock_set),
  .inv_set_i(inv_set), .cmd_wr_i(cmd_wr), .stat_rd_i(stat_rd), .ready_i(ready),
  .done_i(done), .cnt_i(cnt), .status_i(status), .gp_vis_i(gp_vis), .pend_i(pend)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int BUSY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0, secure = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, failures = 0;
  bit wd_hit = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.BUSY_CYCLES(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .secure_i(secure),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata)
  );

  // behavioural reference model
  int        m_cnt, m_op, m_page;
  bit        m_inv, m_locke, m_eol, m_pend;
  bit [15:0] m_lock;
  bit [7:0]  m_gps, m_gpv, m_fmcn;
  bit [1:0]  m_fws;

  task automatic model_step();
    int new_cnt, key, code, pg, rg;
    bit valid, locked;
    new_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
    if (m_pend) begin m_gpv = m_gps; m_pend = 1'b0; end
    if (rd && addr == 2'd2) begin m_inv = 0; m_locke = 0; m_eol = 0; end
    if (m_cnt == 1) begin
      case (m_op)
        2:  begin m_lock[m_page/32] = 1'b1; m_eol = 1'b1; end
        4:  begin m_lock[m_page/32] = 1'b0; m_eol = 1'b1; end
        11: m_gps[m_page] = 1'b1;
        13: m_gps[m_page] = 1'b0;
        default: ;
      endcase
    end
    if (wr && addr == 2'd0) begin m_fmcn = wdata[23:16]; m_fws = wdata[9:8]; end
    if (wr && addr == 2'd1 && m_cnt == 0) begin
      key = wdata[31:24]; code = wdata[7:0]; pg = wdata[17:8]; rg = pg / 32;
      valid = 0; locked = 0;
      case (code)
        1:      begin valid = (rg < 16); if (valid) locked = m_lock[rg]; end
        2, 4:   valid = (rg < 16);
        8:      begin valid = 1; locked = (m_lock != 0); end
        11, 13: valid = (pg < 2);
        default: valid = 0;
      endcase
      if (key != 8'h5A || !valid) m_inv = 1'b1;
      else if (locked)            m_locke = 1'b1;
      else begin new_cnt = BUSY; m_op = code; m_page = pg; end
    end
    m_cnt = new_cnt;
  endtask

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n) m_gps = '0;
    if (!rst_n) begin
      m_cnt = 0; m_op = 0; m_page = 0; m_inv = 0; m_locke = 0; m_eol = 0;
      m_lock = '0; m_gpv = '0; m_pend = 1'b1; m_fmcn = '0; m_fws = '0;
    end else if (por_n) begin
      model_step();
    end
  end

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = '0;
    s[0] = (m_cnt == 0); s[1] = m_eol; s[2] = m_locke; s[3] = m_inv;
    s[4] = secure; s[15:8] = m_gpv; s[31:16] = m_lock;
    return s;
  endfunction

  function automatic string diff_tag(logic [31:0] d);
    if (d[0])          return "R3";
    if (d[1])          return "R12";
    if (d[2])          return "R6";
    if (d[3])          return "R4";
    if (d[4])          return "R13";
    if (d[15:8] != 0)  return "R10";
    return "R5";
  endfunction

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n && por_n && !wd_hit) begin
      if (addr == 2'd2) begin
        checks++;
        if (rdata !== exp_status()) begin
          failures++;
          $display("FAIL %s model status act=%h exp=%h", diff_tag(rdata ^ exp_status()),
                   rdata, exp_status());
        end
      end else if (addr == 2'd0) begin
        checks++;
        if (rdata !== {8'h00, m_fmcn, 6'h00, m_fws, 8'h00}) begin
          failures++;
          $display("FAIL R11 model mode act=%h exp=%h", rdata,
                   {8'h00, m_fmcn, 6'h00, m_fws, 8'h00});
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit w, bit r, bit [1:0] a, bit [31:0] d);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
  endtask

  task automatic idle(int n);
    repeat (n) cyc(0, 0, 2'd2, 32'h0);
  endtask

  task automatic clear_flags();
    cyc(0, 1, 2'd2, 32'h0);
    cyc(0, 0, 2'd2, 32'h0);
  endtask

  function automatic logic [31:0] mk(logic [7:0] key, int page, logic [7:0] code);
    logic [9:0] p;
    p = 10'(page);
    return {key, 6'h00, p, code};
  endfunction

  initial begin
    #(8 * 150000);
    wd_hit = 1'b1;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    idle(1); #2 chk("R1 status after reset", rdata, 32'h0000_0001);
    cyc(0, 0, 2'd0, 0); #2 chk("R1 mode after reset", rdata, 32'h0);

    cyc(1, 0, 2'd0, 32'hFFFF_FFFF);
    cyc(0, 0, 2'd0, 0); #2 chk("R11 mode readback", rdata, 32'h00FF_0300);

    cyc(1, 0, 2'd1, mk(8'h5B, 0, 8'h02));
    idle(1); #2 chk("R2 bad key", rdata, 32'h0000_0009);
    cyc(0, 1, 2'd2, 0); #2 chk("R9 flag visible during read", rdata, 32'h0000_0009);
    idle(1); #2 chk("R9 flag cleared after read", rdata, 32'h0000_0001);

    cyc(1, 0, 2'd1, mk(8'h5A, 0, 8'h03));
    idle(1); #2 chk("R4 bad code", rdata, 32'h0000_0009);
    clear_flags();

    cyc(1, 0, 2'd1, mk(8'h5A, 5, 8'h01));
    for (int i = 0; i < 9; i++) begin
      idle(1); #2;
      if (i == 0) chk("R3 busy after accept", rdata[0], 1'b0);
      if (i == 7) chk("R3 busy last cycle", rdata[0], 1'b0);
      if (i == 8) chk("R3 ready returns", rdata[0], 1'b1);
    end

    cyc(1, 0, 2'd1, mk(8'h5A, 40, 8'h02));
    idle(9); #2 chk("R5 R12 lock region 1", rdata, 32'h0002_0003);
    clear_flags(); #2 chk("R9 eol cleared", rdata, 32'h0002_0001);

    cyc(1, 0, 2'd1, mk(8'h5A, 0, 8'h02));
    cyc(1, 0, 2'd1, mk(8'h5B, 0, 8'h01));
    cyc(1, 0, 2'd1, mk(8'h5A, 64, 8'h02));
    idle(7); #2 chk("R8 writes while busy ignored", rdata, 32'h0003_0003);
    clear_flags();

    cyc(1, 0, 2'd1, mk(8'h5A, 45, 8'h01));
    idle(1); #2 chk("R6 write locked region", rdata, 32'h0003_0005);
    clear_flags();

    cyc(1, 0, 2'd1, mk(8'h5A, 0, 8'h08));
    idle(1); #2 chk("R7 erase refused under lock", rdata, 32'h0003_0005);
    clear_flags();
    cyc(1, 0, 2'd1, mk(8'h5A, 0, 8'h04));  idle(9);
    cyc(1, 0, 2'd1, mk(8'h5A, 32, 8'h04)); idle(9);
    clear_flags(); #2 chk("R5 lock clear", rdata, 32'h0000_0001);
    cyc(1, 0, 2'd1, mk(8'h5A, 0, 8'h08));
    idle(1); #2 chk("R7 erase runs", rdata, 32'h0000_0000);
    idle(8); #2 chk("R7 erase done", rdata, 32'h0000_0001);

    cyc(1, 0, 2'd1, mk(8'h5A, 512, 8'h02));
    idle(1); #2 chk("R4 page beyond plane", rdata, 32'h0000_0009);
    clear_flags();
    cyc(1, 0, 2'd1, mk(8'h5A, 511, 8'h02));
    idle(9); #2 chk("R5 last region", rdata, 32'h8000_0003);
    clear_flags();

    cyc(1, 0, 2'd1, mk(8'h5A, 1, 8'h0B));
    idle(9); #2 chk("R10 option bit hidden", rdata, 32'h8000_0001);
    cyc(1, 0, 2'd1, mk(8'h5A, 2, 8'h0B));
    idle(1); #2 chk("R4 option index range", rdata, 32'h8000_0009);
    clear_flags();

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #2 chk("R1 locks cleared by reset", rdata, 32'h0000_0001);
    idle(1); #2 chk("R10 option bit after reset", rdata, 32'h0000_0201);

    @(negedge clk); secure = 1'b1;
    #2 chk("R13 secure mirror", rdata, 32'h0000_0211);
    @(negedge clk); secure = 1'b0;
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule